// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer

This block is a watchdog counter that software sets up through four 8-bit registers. A nonzero timeout value starts a down-count. The count advances on a seconds tick, or on a minute strobe that the block derives from that tick. Software reloads the count by writing a reload bit. Enabled peripheral activity strobes (game port, keyboard interrupt, mouse interrupt) reload it as well.

When the count runs out, a sticky status bit sets and a level timeout output asserts. If a valid interrupt number is mapped, a one-cycle interrupt pulse also fires. A timeout can be forced directly, either by a self-clearing control bit or by a rising edge on an external keyboard-controller line. A power-LED output can be made to toggle on every seconds tick.

Registers are written through a single-cycle write strobe with a 2-bit address. Reads are combinational from the same address.

Top module: `wdog_event_timer`

## Requirements
- R1: Register addresses are 0 = units, 1 = timeout, 2 = config and 3 = control. After reset, units reads 0x80 and the other three read 0x00. All eight bits of the units register read back as written.
- R2: A timeout value of 0 disables the watchdog. Writing 0 clears the status bit and deasserts `wdt_out`. While the value is 0, seconds ticks never cause a timeout.
- R3: Writing a nonzero timeout N loads the counter and clears the status bit. When units bit 7 is 1 (seconds), the N-th following seconds tick sets control bit 0 and asserts `wdt_out`, which is high when asserted with the default polarity.
- R4: When units bit 7 is 0 (minutes), the counter steps once per SEC_PER_MIN seconds ticks. The minute prescaler restarts at every counter load or reload.
- R5: Writing config with bit 3 set reloads the counter from the timeout register and clears the status bit. Config bit 3 always reads 0.
- R6: A one-cycle strobe on `game_evt`, `kbd_evt` or `mouse_evt` reloads the counter only when config bit 0, 1 or 2 (respectively) is set. Otherwise the strobe has no effect.
- R7: The status bit and `wdt_out` stay asserted until either a control write with bit 0 = 1 or a reload happens.
- R8: On a timeout event, `irq_pulse` is high for exactly one cycle, aligned with the status bit rising, and `irq_num` shows config bits 7:4. A map value of 0 or 2 produces no pulse.
- R9: Writing control with bit 2 set forces an immediate timeout. Control bit 2 always reads 0.
- R10: While control bit 3 is set, a rising edge on `kbc_force` forces a timeout. A level held high does not retrigger the timeout, and edges are ignored when control bit 3 is clear.
- R11: While control bit 1 is set, `led_out` toggles on every seconds tick. While control bit 1 is clear, `led_out` is 0.
- R12: When a force coincides in the same cycle with a reload or a status clear, the force wins and the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| sec_tick | input | 1 | One-cycle pulse per second |
| game_evt | input | 1 | Game port activity strobe |
| kbd_evt | input | 1 | Keyboard interrupt strobe |
| mouse_evt | input | 1 | Mouse interrupt strobe |
| kbc_force | input | 1 | External force line, rising-edge sensitive |
| wdt_out | output | 1 | Timeout level (polarity set by OUT_INVERT) |
| irq_pulse | output | 1 | One-cycle timeout interrupt |
| irq_num | output | 4 | Mapped interrupt number |
| led_out | output | 1 | Power-LED toggle output |

## Verification
The assertions assume that `sec_tick` and the activity strobes are single-cycle pulses. They also assume that `addr` and `wr_data` are valid whenever `wr_en` is high. The bench drives every input on the falling edge. It follows each tick or strobe with at least one idle cycle, and it never overlaps register writes with ticks, except in the one deliberate force-versus-reload collision.

// File: rtl/wdog_event_timer.sv
module wdog_event_timer #(
  parameter int SEC_PER_MIN = 60,
  parameter bit OUT_INVERT  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sec_tick,
  input  logic       game_evt,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  input  logic       kbc_force,
  output logic       wdt_out,
  output logic       irq_pulse,
  output logic [3:0] irq_num,
  output logic       led_out
);

  localparam int PW = $clog2(SEC_PER_MIN + 1);
  localparam logic [1:0] A_UNITS = 2'd0;
  localparam logic [1:0] A_TMO   = 2'd1;
  localparam logic [1:0] A_CFG   = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;

  logic [7:0]    units_q, tmo_q, cnt_q;
  logic [3:0]    map_q;
  logic [2:0]    evt_en_q;
  logic          led_en_q, ext_en_q, status_q, kbc_q, led_q, irq_q;
  logic [PW-1:0] pre_q;

  logic wr_units, wr_tmo, wr_cfg, wr_ctrl;
  logic reload, force_evt, clear, unit_tick, dec, expire, min_strobe;

  assign wr_units = wr_en && addr == A_UNITS;
  assign wr_tmo   = wr_en && addr == A_TMO;
  assign wr_cfg   = wr_en && addr == A_CFG;
  assign wr_ctrl  = wr_en && addr == A_CTRL;

  assign reload     = (wr_cfg && wr_data[3]) || |(evt_en_q & {mouse_evt, kbd_evt, game_evt})
                      || (wr_tmo && wr_data != 8'd0);
  assign force_evt  = (wr_ctrl && wr_data[2]) || (ext_en_q && kbc_force && !kbc_q);
  assign clear      = (wr_ctrl && wr_data[0]) || reload || (wr_tmo && wr_data == 8'd0);
  assign min_strobe = sec_tick && pre_q == PW'(SEC_PER_MIN - 1);
  assign unit_tick  = units_q[7] ? sec_tick : min_strobe;
  assign dec        = tmo_q != 8'd0 && !status_q && unit_tick && cnt_q != 8'd0;
  assign expire     = force_evt || (!reload && !wr_tmo && dec && cnt_q == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q  <= 8'h80;
      tmo_q    <= 8'd0;
      cnt_q    <= 8'd0;
      map_q    <= 4'd0;
      evt_en_q <= 3'd0;
      led_en_q <= 1'b0;
      ext_en_q <= 1'b0;
      status_q <= 1'b0;
      kbc_q    <= 1'b0;
      led_q    <= 1'b0;
      irq_q    <= 1'b0;
      pre_q    <= '0;
    end else begin
      kbc_q <= kbc_force;
      if (wr_units) units_q <= wr_data;
      if (wr_tmo)   tmo_q   <= wr_data;
      if (wr_cfg) begin
        map_q    <= wr_data[7:4];
        evt_en_q <= wr_data[2:0];
      end
      if (wr_ctrl) begin
        led_en_q <= wr_data[1];
        ext_en_q <= wr_data[3];
      end

      if (wr_tmo)      cnt_q <= wr_data;
      else if (reload) cnt_q <= tmo_q;
      else if (dec)    cnt_q <= cnt_q - 8'd1;

      if (reload || wr_tmo) pre_q <= '0;
      else if (sec_tick)    pre_q <= min_strobe ? '0 : pre_q + 1'b1;

      if (force_evt)   status_q <= 1'b1;
      else if (clear)  status_q <= 1'b0;
      else if (expire) status_q <= 1'b1;

      irq_q <= expire && map_q != 4'd0 && map_q != 4'd2;

      if (!led_en_q)     led_q <= 1'b0;
      else if (sec_tick) led_q <= !led_q;
    end
  end

  always_comb begin
    case (addr)
      A_UNITS: rd_data = units_q;
      A_TMO:   rd_data = tmo_q;
      A_CFG:   rd_data = {map_q, 1'b0, evt_en_q};
      default: rd_data = {4'd0, ext_en_q, 1'b0, led_en_q, status_q};
    endcase
  end

  assign wdt_out   = status_q ^ OUT_INVERT;
  assign irq_pulse = irq_q;
  assign irq_num   = map_q;
  assign led_out   = led_q;

  // R8
  irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(map_q) != 4'd0 && $past(map_q) != 4'd2));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clear) |=> status_q);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(force_evt || (unit_tick && cnt_q == 8'd1)));

  // R2
  disabled_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q == 8'd0 && !wr_tmo) |=> $stable(cnt_q));

  // R11
  led_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !led_en_q |=> !led_q);

  // R5
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> $past(reload || wr_tmo));

endmodule

// File: tb/tb_wdog_event_timer.sv
`timescale 1ns/1ps
module tb_wdog_event_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0, rd_data;
  logic sec_tick = 1'b0, game_evt = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0, kbc_force = 1'b0;
  logic wdt_out, irq_pulse, led_out;
  logic [3:0] irq_num;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  wdog_event_timer #(.SEC_PER_MIN(4), .OUT_INVERT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sec_tick(sec_tick), .game_evt(game_evt), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .kbc_force(kbc_force), .wdt_out(wdt_out),
    .irq_pulse(irq_pulse), .irq_num(irq_num), .led_out(led_out));

  // {req[3:0], op[1:0], addr[1:0], data[7:0], exp[7:0]}; op 0 write, 1 read, 2 ticks, 3 outputs {led,wdt}
  localparam int NV = 45;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 2'd1, 2'd0, 8'h00, 8'h80},  // R1 reset values
    {4'd1, 2'd1, 2'd1, 8'h00, 8'h00},
    {4'd1, 2'd1, 2'd2, 8'h00, 8'h00},
    {4'd1, 2'd1, 2'd3, 8'h00, 8'h00},
    {4'd1, 2'd0, 2'd0, 8'hD5, 8'h00},
    {4'd1, 2'd1, 2'd0, 8'h00, 8'hD5},
    {4'd3, 2'd0, 2'd1, 8'h03, 8'h00},  // R3 seconds count
    {4'd3, 2'd1, 2'd1, 8'h00, 8'h03},
    {4'd3, 2'd2, 2'd0, 8'd2,  8'h00},
    {4'd3, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd3, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd3, 2'd3, 2'd0, 8'h00, 8'h01},
    {4'd3, 2'd1, 2'd3, 8'h00, 8'h01},
    {4'd7, 2'd0, 2'd3, 8'h01, 8'h00},  // R7 clear by control bit 0
    {4'd7, 2'd1, 2'd3, 8'h00, 8'h00},
    {4'd7, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd5, 2'd0, 2'd2, 8'h08, 8'h00},  // R5 software reload
    {4'd5, 2'd1, 2'd2, 8'h00, 8'h00},
    {4'd5, 2'd2, 2'd0, 8'd2,  8'h00},
    {4'd5, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd5, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd5, 2'd3, 2'd0, 8'h00, 8'h01},
    {4'd2, 2'd0, 2'd1, 8'h00, 8'h00},  // R2 disable
    {4'd2, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd4, 2'd0, 2'd0, 8'h00, 8'h00},  // R4 minutes
    {4'd4, 2'd0, 2'd1, 8'h02, 8'h00},
    {4'd4, 2'd2, 2'd0, 8'd7,  8'h00},
    {4'd4, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd4, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd4, 2'd3, 2'd0, 8'h00, 8'h01},
    {4'd11, 2'd0, 2'd3, 8'h03, 8'h00}, // R11 LED toggle
    {4'd11, 2'd1, 2'd3, 8'h00, 8'h02},
    {4'd11, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd11, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd11, 2'd3, 2'd0, 8'h00, 8'h02},
    {4'd11, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd11, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd11, 2'd2, 2'd0, 8'd1,  8'h00},
    {4'd11, 2'd3, 2'd0, 8'h00, 8'h02},
    {4'd11, 2'd0, 2'd3, 8'h00, 8'h00},
    {4'd11, 2'd3, 2'd0, 8'h00, 8'h00},
    {4'd9, 2'd0, 2'd1, 8'h05, 8'h00},  // R9 forced timeout
    {4'd9, 2'd0, 2'd3, 8'h04, 8'h00},
    {4'd9, 2'd1, 2'd3, 8'h00, 8'h01},
    {4'd9, 2'd3, 2'd0, 8'h00, 8'h01}
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic chk_out(input logic exp, input string req);
    #1 check(wdt_out == exp, req, {7'd0, wdt_out}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [23:0] e;
      string rq;
      e = VEC[i];
      rq = $sformatf("R%0d vec%0d", e[23:20], i);
      case (e[19:18])
        2'd0: wr(e[17:16], e[15:8]);
        2'd1: rd(e[17:16], e[7:0], rq);
        2'd2: ticks(int'(e[15:8]));
        default: begin
          @(negedge clk); #1;
          check({led_out, wdt_out} == e[1:0], rq, {6'd0, led_out, wdt_out}, e[7:0]);
        end
      endcase
    end

    // R8 and R6: game event reload, irq pulse on mapped line 5
    wr(2'd0, 8'h80); wr(2'd2, 8'h51); wr(2'd1, 8'h02);
    ticks(1);
    @(negedge clk); game_evt = 1'b1; @(negedge clk); game_evt = 1'b0;
    ticks(1); chk_out(1'b0, "R6 game reload");
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; #1;
    check(irq_pulse && irq_num == 4'd5, "R8 pulse", {3'd0, irq_pulse, irq_num}, 8'h15);
    chk_out(1'b1, "R8 status");
    @(negedge clk); #1 check(!irq_pulse, "R8 single cycle", {7'd0, irq_pulse}, 8'h00);

    // R6: keyboard strobe ignored while its enable is clear
    wr(2'd2, 8'h01); wr(2'd1, 8'h02);
    ticks(1);
    @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
    ticks(1); chk_out(1'b1, "R6 kbd ignored");
    // R6 and R7: enabled mouse strobe reloads and clears status
    wr(2'd2, 8'h04);
    @(negedge clk); mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
    chk_out(1'b0, "R7 reload clears");
    ticks(1); chk_out(1'b0, "R6 mouse reload");
    ticks(1); chk_out(1'b1, "R6 mouse expire");

    // R8: map value 2 is invalid
    wr(2'd2, 8'h20); wr(2'd1, 8'h01);
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; #1;
    check(!irq_pulse, "R8 map 2 silent", {7'd0, irq_pulse}, 8'h00);
    chk_out(1'b1, "R8 map 2 status");

    // R10: external rising edge force
    wr(2'd3, 8'h09); wr(2'd1, 8'h09);
    chk_out(1'b0, "R10 pre");
    @(negedge clk); kbc_force = 1'b1;
    @(negedge clk); chk_out(1'b1, "R10 edge");
    wr(2'd3, 8'h09);
    repeat (2) @(negedge clk);
    chk_out(1'b0, "R10 level no retrigger");
    wr(2'd3, 8'h01);
    @(negedge clk); kbc_force = 1'b0;
    @(negedge clk); kbc_force = 1'b1;
    repeat (2) @(negedge clk);
    chk_out(1'b0, "R10 disabled");
    kbc_force = 1'b0;

    // R12: force coincides with a game-event reload
    wr(2'd2, 8'h01); wr(2'd1, 8'h09);
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wr_data = 8'h05; game_evt = 1'b1;
    @(negedge clk); wr_en = 1'b0; game_evt = 1'b0;
    chk_out(1'b1, "R12 force wins");
    rd(2'd3, 8'h01, "R9 bit 2 reads 0");

    // R2: timeout 0 ignores ticks
    wr(2'd1, 8'h00);
    chk_out(1'b0, "R2 write 0 clears");
    ticks(3);
    chk_out(1'b0, "R2 ticks ignored");

    // R1: reset mid-run
    wr(2'd1, 8'h07); wr(2'd0, 8'h11);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, 8'h80, "R1 units after reset");
    rd(2'd1, 8'h00, "R1 timeout after reset");
    chk_out(1'b0, "R1 out after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule